// File: doc/BRIEF.md
# DMA Stream Count and Termination Unit

This unit tracks the item count of one DMA stream and decides when the stream ends. It models the bus side as a single completion strobe per item. The pacing can come from the DMA engine or from the peripheral. When the DMA engine paces the stream, the count loads from the programmed item number and the stream ends when that count runs out. When the peripheral paces the stream, the count starts from the all-ones maximum and runs down. The peripheral ends the stream with a single or burst last-request. If that request never arrives, the stream is forced off when the count reaches zero. Software recovers the number of items moved as the maximum minus the remaining count.

A stream starts on a rising edge of the enable input. At that moment the mode fields are checked. An illegal combination keeps the stream idle and raises a sticky configuration-error flag. A legal start latches the mode, loads the counter and raises the active flag. The transfer-complete flag is sticky and is cleared by a one-cycle clear pulse.

Top module: `dmat_stream_term`

## Requirements
- R1: After synchronous reset, remaining is 0 and active, tc_flag and cfg_err are 0.
- R2: A start is a rising edge of en while the stream is idle. A legal start with DMA pacing loads remaining with cfg_items and sets active in the same clock edge. Each xfer_done while active lowers remaining by one.
- R3: A legal start with peripheral pacing loads remaining with all ones (0xFFFF at the default width). The items moved always equal all ones minus remaining.
- R4: With peripheral pacing, last_single or last_burst marks the next completed item as the final one. If xfer_done comes in the same cycle, that item is the final one. The stream goes inactive at that completion, tc_flag is set, and remaining keeps the decremented value.
- R5: Without circular mode, an item completion that brings remaining to 0 ends the stream and sets tc_flag, under either pacing.
- R6: cfg_dir encodes 0 = peripheral to memory, 1 = memory to peripheral, 2 = memory to memory, 3 = reserved. With direction 2, pacing is forced to the DMA engine, flow_periph reads 0, and remaining loads cfg_items.
- R7: A start attempt with an illegal setup leaves active at 0 and sets cfg_err. Illegal setups are:
  - peripheral pacing with circular or double-buffer mode;
  - direction 2 with circular or direct mode;
  - direct mode with burst type;
  - direction 3;
  - DMA pacing with cfg_items of 0.
  A later legal start clears cfg_err.
- R8: tc_flag stays set until a tc_clear pulse. If a completion event and tc_clear occur in the same cycle, tc_flag stays set.
- R9: Lowering en while active makes the stream inactive at the next clock edge. An item completing in that cycle is still counted. remaining is then frozen, and tc_flag is not set unless that item was the final one.
- R10: With DMA pacing, last_single and last_burst have no effect on remaining or active.
- R11: In circular mode with DMA pacing, a completion that brings the count to 0 reloads cfg_items, sets tc_flag and keeps active at 1.
- R12: xfer_done while the stream is idle leaves remaining unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Stream enable; a rising edge starts the stream, a low level stops it |
| cfg_dir | input | 2 | Transfer direction code |
| cfg_periph_flow | input | 1 | Requests peripheral pacing |
| cfg_circular | input | 1 | Circular mode |
| cfg_dbuf | input | 1 | Double-buffer mode |
| cfg_direct | input | 1 | Direct mode (no FIFO) |
| cfg_burst | input | 1 | Burst transfer type (0 = single) |
| cfg_items | input | CNT_W | Programmed item count |
| xfer_done | input | 1 | One item completed on the bus |
| last_single | input | 1 | Peripheral last single request |
| last_burst | input | 1 | Peripheral last burst request |
| tc_clear | input | 1 | Clears tc_flag |
| remaining | output | CNT_W | Remaining item count |
| active | output | 1 | Stream running |
| tc_flag | output | 1 | Sticky transfer complete |
| cfg_err | output | 1 | Sticky illegal-setup flag |
| flow_periph | output | 1 | Effective pacing for the current setup (1 = peripheral) |

## Verification
The bench keeps CNT_W at its default of 16. At that width the all-ones start value is 65535 items. A run with peripheral pacing that never sends a last-request can therefore exhaust the whole count in about 65,000 cycles, which reaches the forced-stop case. The same width makes the items-moved figure directly comparable with the 0xFFFF formula. Short programmed counts of 1 to 10 reach the DMA-paced end, the circular reload and the clear/set collision in a few cycles.

// File: rtl/dmat_pkg.sv
package dmat_pkg;

    localparam int DEF_CNT_W = 16;

    typedef enum logic [1:0] {
        DIR_P2M  = 2'd0,
        DIR_M2P  = 2'd1,
        DIR_M2M  = 2'd2,
        DIR_RSVD = 2'd3
    } dir_e;

    typedef struct packed {
        dir_e dir;
        logic periph_flow;
        logic circular;
        logic dbuf;
        logic direct;
        logic burst;
    } mode_cfg_t;

    typedef struct packed {
        logic periph_flow;
        logic circular;
    } run_mode_t;

    // pacing actually used: memory-to-memory always runs under the DMA engine
    function automatic logic eff_periph_flow(mode_cfg_t c);
        return c.periph_flow && (c.dir != DIR_M2M);
    endfunction

    function automatic logic cfg_illegal(mode_cfg_t c, logic zero_items);
        logic pf;
        pf = eff_periph_flow(c);
        return (c.dir == DIR_RSVD)
            || (pf && (c.circular || c.dbuf))
            || ((c.dir == DIR_M2M) && (c.circular || c.direct))
            || (c.direct && c.burst)
            || (!pf && zero_items);
    endfunction

endpackage

// File: rtl/dmat_cfg_check.sv
module dmat_cfg_check
    import dmat_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  mode_cfg_t          cfg,
    input  logic [CNT_W-1:0]   items,
    output logic               periph_flow,
    output logic               illegal,
    output logic [CNT_W-1:0]   start_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_comb begin
        periph_flow = eff_periph_flow(cfg);
        illegal     = cfg_illegal(cfg, items == '0);
        start_count = periph_flow ? CNT_MAX : items;
    end
endmodule

// File: rtl/dmat_counter.sv
module dmat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_src,
    input  logic             dec,
    input  logic             reload,
    output logic [CNT_W-1:0] count,
    output logic             last_item
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
        end else if (load) begin
            count_q  <= load_val;
            reload_q <= reload_src;
        end else if (reload) begin
            count_q  <= reload_q;
        end else if (dec) begin
            count_q  <= count_q - ONE;
        end
    end

    assign count     = count_q;
    assign last_item = (count_q == ONE);
endmodule

// File: rtl/dmat_ctrl.sv
module dmat_ctrl
    import dmat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic xfer_done,
    input  logic last_req,
    input  logic tc_clear,
    input  logic illegal,
    input  logic start_pf,
    input  logic start_circ,
    input  logic last_item,
    output logic active,
    output logic tc_flag,
    output logic cfg_err,
    output logic load,
    output logic dec,
    output logic reload
);
    logic      en_q, active_q, tc_q, err_q, last_pend_q;
    run_mode_t mode_q;
    logic      start_try, last_now, ends_by_last, hit_zero, term, tc_set;

    always_comb begin
        start_try    = en && !en_q && !active_q;
        load         = start_try && !illegal;
        dec          = active_q && xfer_done;
        last_now     = active_q && mode_q.periph_flow && last_req;
        ends_by_last = dec && (last_pend_q || last_now);
        hit_zero     = dec && last_item && !ends_by_last;
        reload       = hit_zero && mode_q.circular;
        term         = ends_by_last || (hit_zero && !mode_q.circular);
        tc_set       = term || reload;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= 1'b0;
            active_q    <= 1'b0;
            tc_q        <= 1'b0;
            err_q       <= 1'b0;
            last_pend_q <= 1'b0;
            mode_q      <= '0;
        end else begin
            en_q <= en;
            if (load) begin
                active_q    <= 1'b1;
                last_pend_q <= 1'b0;
                mode_q      <= '{periph_flow: start_pf, circular: start_circ};
            end else if (active_q && (term || !en)) begin
                active_q <= 1'b0;
            end else if (last_now && !dec) begin
                last_pend_q <= 1'b1;
            end
            if (load)
                err_q <= 1'b0;
            else if (start_try)
                err_q <= 1'b1;
            if (tc_set)
                tc_q <= 1'b1;
            else if (tc_clear)
                tc_q <= 1'b0;
        end
    end

    assign active  = active_q;
    assign tc_flag = tc_q;
    assign cfg_err = err_q;

    // R8
    tc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_q && !tc_clear) |=> tc_q);

    // R7
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> !active_q);

    // R4
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && last_pend_q && xfer_done) |=> !active_q);

    // R10
    dma_ignores_last_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !mode_q.periph_flow && en && !xfer_done) |=> active_q);
endmodule

// File: rtl/dmat_stream_term.sv
module dmat_stream_term
    import dmat_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       cfg_dir,
    input  logic             cfg_periph_flow,
    input  logic             cfg_circular,
    input  logic             cfg_dbuf,
    input  logic             cfg_direct,
    input  logic             cfg_burst,
    input  logic [CNT_W-1:0] cfg_items,
    input  logic             xfer_done,
    input  logic             last_single,
    input  logic             last_burst,
    input  logic             tc_clear,
    output logic [CNT_W-1:0] remaining,
    output logic             active,
    output logic             tc_flag,
    output logic             cfg_err,
    output logic             flow_periph
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    mode_cfg_t        cfg_s;
    logic             illegal, load, dec, reload, last_item;
    logic [CNT_W-1:0] start_count;

    always_comb begin
        cfg_s.dir         = dir_e'(cfg_dir);
        cfg_s.periph_flow = cfg_periph_flow;
        cfg_s.circular    = cfg_circular;
        cfg_s.dbuf        = cfg_dbuf;
        cfg_s.direct      = cfg_direct;
        cfg_s.burst       = cfg_burst;
    end

    dmat_cfg_check #(.CNT_W(CNT_W)) chk_i (
        .cfg         (cfg_s),
        .items       (cfg_items),
        .periph_flow (flow_periph),
        .illegal     (illegal),
        .start_count (start_count)
    );

    dmat_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (start_count),
        .reload_src (cfg_items),
        .dec        (dec),
        .reload     (reload),
        .count      (remaining),
        .last_item  (last_item)
    );

    dmat_ctrl ctl_i (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .xfer_done  (xfer_done),
        .last_req   (last_single || last_burst),
        .tc_clear   (tc_clear),
        .illegal    (illegal),
        .start_pf   (flow_periph),
        .start_circ (cfg_circular),
        .last_item  (last_item),
        .active     (active),
        .tc_flag    (tc_flag),
        .cfg_err    (cfg_err),
        .load       (load),
        .dec        (dec),
        .reload     (reload)
    );

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && xfer_done && remaining != ONE) |=> remaining == $past(remaining) - ONE);

    // R12
    idle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> (active || $stable(remaining)));

    // R3
    start_value_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> remaining == ($past(flow_periph) ? CNT_MAX : $past(cfg_items)));

    // R5
    tc_from_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_flag) |-> $past(active));
endmodule

// File: tb/dmat_stream_term_tb_top.sv
module dmat_stream_term_tb_top;
    localparam int W    = 16;
    localparam int MAXC = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, pf = 0, circ = 0, dbuf = 0, direct = 0, burst = 0;
    logic [1:0] dir = 2'd0;
    logic [W-1:0] items = '0;
    logic xfer = 0, lsng = 0, lbst = 0, clr = 0;
    logic [W-1:0] remaining;
    logic active, tc_flag, cfg_err, flow_periph;

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    // behavioural reference state
    int  m_rem = 0, m_reload = 0;
    bit  m_act = 0, m_tc = 0, m_err = 0, m_enq = 0, m_lastp = 0, m_pf = 0, m_circ = 0;

    always #10 clk = ~clk;

    dmat_stream_term #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .en(en), .cfg_dir(dir), .cfg_periph_flow(pf),
        .cfg_circular(circ), .cfg_dbuf(dbuf), .cfg_direct(direct), .cfg_burst(burst),
        .cfg_items(items), .xfer_done(xfer), .last_single(lsng), .last_burst(lbst),
        .tc_clear(clr), .remaining(remaining), .active(active), .tc_flag(tc_flag),
        .cfg_err(cfg_err), .flow_periph(flow_periph)
    );

    function automatic bit ref_pf();
        return pf && (dir != 2'd2);
    endfunction

    function automatic bit ref_bad();
        bit p;
        p = ref_pf();
        if (dir == 2'd3) return 1;
        if (p && (circ || dbuf)) return 1;
        if (dir == 2'd2 && (circ || direct)) return 1;
        if (direct && burst) return 1;
        if (!p && items == 0) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit tcset, term, lnow;
        tcset = 0;
        term  = 0;
        if (rst) begin
            m_rem = 0; m_act = 0; m_tc = 0; m_err = 0; m_enq = 0; m_lastp = 0;
        end else begin
            if (!m_act) begin
                if (en && !m_enq) begin
                    if (ref_bad()) m_err = 1;
                    else begin
                        m_err = 0; m_act = 1; m_lastp = 0;
                        m_pf = ref_pf(); m_circ = circ; m_reload = items;
                        m_rem = m_pf ? MAXC : int'(items);
                    end
                end
            end else begin
                lnow = m_pf && (lsng || lbst);
                if (xfer) begin
                    m_rem = m_rem - 1;
                    if (m_lastp || lnow) term = 1;
                    else if (m_rem == 0) begin
                        if (m_circ) begin m_rem = m_reload; tcset = 1; end
                        else term = 1;
                    end
                end else if (lnow) m_lastp = 1;
                if (term) begin m_act = 0; tcset = 1; end
                if (!en) m_act = 0;
            end
            if (tcset) m_tc = 1;
            else if (clr) m_tc = 0;
            m_enq = en;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (cycles > 0 && !finished) begin
            chk("R2 remaining vs model", 32'(remaining), 32'(m_rem));
            chk("R9 active vs model", 32'(active), 32'(m_act));
            chk("R8 tc_flag vs model", 32'(tc_flag), 32'(m_tc));
            chk("R7 cfg_err vs model", 32'(cfg_err), 32'(m_err));
            chk("R6 flow_periph vs model", 32'(flow_periph), 32'(ref_pf()));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setup(logic [1:0] d, bit p, bit c, bit db, bit dr, bit bu, int n);
        dir = d; pf = p; circ = c; dbuf = db; direct = dr; burst = bu; items = W'(n);
    endtask

    task automatic start();
        en = 1; tick();
    endtask

    task automatic stop();
        en = 0; tick();
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            xfer = 1; tick();
        end
        xfer = 0;
    endtask

    task automatic clear_tc();
        clr = 1; tick(); clr = 0;
    endtask

    initial begin
        @(negedge clk); tick(); tick();
        rst = 0;
        // R1 reset values
        chk("R1 remaining", 32'(remaining), 0);
        chk("R1 active", 32'(active), 0);
        chk("R1 tc_flag", 32'(tc_flag), 0);
        chk("R1 cfg_err", 32'(cfg_err), 0);

        // DMA paced, 5 items
        setup(2'd0, 0, 0, 0, 0, 0, 5);
        start();
        chk("R2 load", 32'(remaining), 5);
        chk("R2 active", 32'(active), 1);
        pulses(2);
        chk("R2 decrement", 32'(remaining), 3);
        pulses(3);
        chk("R5 zero ends", 32'(active), 0);
        chk("R5 tc", 32'(tc_flag), 1);
        chk("R5 rem", 32'(remaining), 0);
        stop();
        clear_tc();
        chk("R8 cleared", 32'(tc_flag), 0);

        // peripheral paced, last single after three items
        setup(2'd0, 1, 0, 0, 0, 0, 7);
        start();
        chk("R3 start max", 32'(remaining), 32'hFFFF);
        chk("R6 flow periph", 32'(flow_periph), 1);
        pulses(3);
        lsng = 1; tick(); lsng = 0;
        chk("R4 still active", 32'(active), 1);
        pulses(1);
        chk("R4 stopped", 32'(active), 0);
        chk("R4 tc", 32'(tc_flag), 1);
        chk("R3 items moved", 32'(MAXC - int'(remaining)), 4);
        pulses(1);
        chk("R12 idle xfer", 32'(remaining), 32'hFFFB);
        stop();
        clear_tc();

        // last burst together with completion
        start();
        pulses(2);
        lbst = 1; xfer = 1; tick(); lbst = 0; xfer = 0;
        chk("R4 burst same cycle", 32'(active), 0);
        chk("R4 burst rem", 32'(remaining), 32'hFFFC);
        stop();
        clear_tc();

        // completion colliding with clear
        setup(2'd1, 0, 0, 0, 0, 0, 1);
        start();
        xfer = 1; clr = 1; tick(); xfer = 0; clr = 0;
        chk("R8 set wins", 32'(tc_flag), 1);
        stop();
        clear_tc();

        // memory to memory forces DMA pacing; last requests ignored
        setup(2'd2, 1, 0, 0, 0, 0, 4);
        chk("R6 forced dma", 32'(flow_periph), 0);
        start();
        chk("R6 loads items", 32'(remaining), 4);
        lsng = 1; xfer = 1; tick(); lsng = 0; xfer = 0;
        chk("R10 ignored rem", 32'(remaining), 3);
        chk("R10 ignored act", 32'(active), 1);
        lbst = 1; tick(); lbst = 0;
        pulses(1);
        chk("R10 burst ignored", 32'(active), 1);
        pulses(2);
        chk("R5 m2m end", 32'(active), 0);
        stop();
        clear_tc();

        // illegal setups
        for (int k = 0; k < 7; k++) begin
            case (k)
                0: setup(2'd0, 1, 1, 0, 0, 0, 3);
                1: setup(2'd1, 1, 0, 1, 0, 0, 3);
                2: setup(2'd2, 0, 1, 0, 0, 0, 3);
                3: setup(2'd2, 0, 0, 0, 1, 0, 3);
                4: setup(2'd0, 0, 0, 0, 1, 1, 3);
                5: setup(2'd3, 0, 0, 0, 0, 0, 3);
                default: setup(2'd0, 0, 0, 0, 0, 0, 0);
            endcase
            start();
            chk($sformatf("R7 err case %0d", k), 32'(cfg_err), 1);
            chk($sformatf("R7 idle case %0d", k), 32'(active), 0);
            stop();
        end
        setup(2'd0, 0, 0, 0, 1, 0, 2);
        start();
        chk("R7 legal clears", 32'(cfg_err), 0);
        chk("R7 legal runs", 32'(active), 1);
        stop();
        chk("R9 en low stops", 32'(active), 0);
        chk("R9 no tc", 32'(tc_flag), 0);
        chk("R9 frozen", 32'(remaining), 2);

        // enable dropped together with a completion
        setup(2'd0, 0, 0, 0, 0, 0, 10);
        start();
        pulses(3);
        en = 0; xfer = 1; tick(); xfer = 0;
        chk("R9 counted", 32'(remaining), 6);
        chk("R9 inactive", 32'(active), 0);
        chk("R9 tc clear", 32'(tc_flag), 0);
        pulses(2);
        chk("R12 no count", 32'(remaining), 6);

        // circular, DMA paced
        setup(2'd0, 0, 1, 0, 0, 0, 3);
        start();
        pulses(3);
        chk("R11 reload", 32'(remaining), 3);
        chk("R11 active", 32'(active), 1);
        chk("R11 tc", 32'(tc_flag), 1);
        clear_tc();
        pulses(2);
        chk("R11 continues", 32'(remaining), 1);
        stop();

        // peripheral paced, no last request: forced end at zero
        setup(2'd0, 1, 0, 0, 0, 0, 0);
        start();
        pulses(MAXC);
        chk("R5 forced stop", 32'(active), 0);
        chk("R5 forced tc", 32'(tc_flag), 1);
        chk("R3 all items", 32'(MAXC - int'(remaining)), 32'(MAXC));
        stop();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule